// File: doc/BRIEF.md
# Hi/Lo Multiply-Divide Unit

This block is the integer multiply and divide engine of a 32-bit processor core. It takes signed or unsigned multiply and divide commands and works through them one bit per cycle. The result goes into two dedicated result registers: the high word register and the low word register. A multiply leaves the low half of the 64-bit product in the low register and the upper half in the high register. A divide leaves the quotient in the low register and the remainder in the high register.

Move commands let the pipeline read either register, or load either one from an operand. The command port follows a valid/ready rule. While an arithmetic operation runs, `cmd_ready` is low, so a move command waits at the port and is taken once the results are written. A move-from therefore always returns the finished result. A move-to is applied after the running operation has finished and is never overwritten by it.

Divide by zero raises no trap. It produces fixed values, so software can detect the case after the fact. Overflow handling and copying results into general registers belong to the surrounding core.

Top module: `hilo_muldiv`

## Requirements
- R1: After reset, both result registers read zero, `busy` and `rd_valid` are low and `cmd_ready` is high.
- R2: An unsigned multiply (`cmd_op` = 1) writes bits 31:0 of the 64-bit product of `cmd_a` and `cmd_b` to the low register and bits 63:32 to the high register.
- R3: A signed multiply (`cmd_op` = 0) treats both operands as two's complement and splits the signed 64-bit product the same way as R2.
- R4: An unsigned divide (`cmd_op` = 3) of `cmd_a` by a nonzero `cmd_b` writes the quotient to the low register and the remainder to the high register.
- R5: A signed divide (`cmd_op` = 2) truncates the quotient toward zero, and the remainder takes the sign of the dividend. The most negative value divided by -1 gives quotient 0x80000000 and remainder 0.
- R6: A divide of either kind with `cmd_b` = 0 leaves the low register all ones and the high register equal to `cmd_a`.
- R7: `busy` rises on the clock edge that accepts an arithmetic command and stays high for exactly 32 cycles. The results are in the registers on the edge where `busy` falls.
- R8: While `busy` is high, `cmd_ready` is low and no command is taken. A move command held at the port is taken after completion: a move-from returns the new result, and a move-to replaces the result.
- R9: A move-from-high (`cmd_op` = 4) or move-from-low (`cmd_op` = 5) that is accepted on an edge makes `rd_valid` high for one cycle after that edge, with the register contents on `rd_data`.
- R10: A move-to-high (`cmd_op` = 6) or move-to-low (`cmd_op` = 7) loads `cmd_a` into the chosen register and leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is presented |
| cmd_op | input | 3 | Command code (see R2 to R10) |
| cmd_a | input | 32 | First operand: multiplicand, dividend or move-to value |
| cmd_b | input | 32 | Second operand: multiplier or divisor |
| cmd_ready | output | 1 | A command can be accepted this cycle |
| busy | output | 1 | An arithmetic operation is running |
| rd_valid | output | 1 | `rd_data` holds a move-from result |
| rd_data | output | 32 | Value returned by a move-from |

## Verification
The hardest case to reach from the ports is a move command that arrives during a running operation and has to wait. It must be taken after the results land, never before. To create it, the bench starts a multiply or divide and keeps a move-from or move-to command valid on the very next cycle. It records that the command had to wait, then checks that a held read returns the new product and a held write replaces the remainder. The signed corner cases need operands chosen to hit them: the most negative dividend, -1 as divisor, and mixed operand signs.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [2:0] {
    OP_MULS = 3'd0,
    OP_MULU = 3'd1,
    OP_DIVS = 3'd2,
    OP_DIVU = 3'd3,
    OP_RDHI = 3'd4,
    OP_RDLO = 3'd5,
    OP_WRHI = 3'd6,
    OP_WRLO = 3'd7
  } mdu_op_e;
endpackage

// File: rtl/mdu_iter.sv
// One bit-step of the shared datapath: shift/add for multiply,
// restoring subtract for divide.
module mdu_iter #(
  parameter int W = 32
) (
  input  logic         active,
  input  logic         is_div,
  input  logic [W:0]   acc_hi,
  input  logic [W-1:0] acc_lo,
  input  logic [W-1:0] mag_b,
  output logic [W:0]   nxt_hi,
  output logic [W-1:0] nxt_lo
);
  // Multiply: add the multiplicand when the low bit is set, then shift right.
  function automatic logic [2*W:0] mul_step(input logic [W:0] h, input logic [W-1:0] l,
                                            input logic [W-1:0] m);
    logic [W:0] sum;
    sum = {1'b0, h[W-1:0]} + (l[0] ? {1'b0, m} : '0);
    return {1'b0, sum, l[W-1:1]};
  endfunction

  // Divide: shift one dividend bit into the remainder, subtract if it fits.
  function automatic logic [2*W:0] div_step(input logic [W:0] h, input logic [W-1:0] l,
                                            input logic [W-1:0] d);
    logic [W:0]   r;
    logic [W-1:0] q;
    r = {h[W-1:0], l[W-1]};
    q = {l[W-2:0], 1'b0};
    if (r >= {1'b0, d}) begin
      r    = r - {1'b0, d};
      q[0] = 1'b1;
    end
    return {r, q};
  endfunction

  logic [2*W:0] step;

  always_comb begin
    step   = is_div ? div_step(acc_hi, acc_lo, mag_b) : mul_step(acc_hi, acc_lo, mag_b);
    nxt_hi = step[2*W:W];
    nxt_lo = step[W-1:0];
  end

  // A partial remainder below a nonzero divisor stays below it.
  always_comb begin
    if (active && is_div && (mag_b != '0) && (acc_hi < {1'b0, mag_b}))
      assert_rem_below_divisor_R4: assert (nxt_hi < {1'b0, mag_b});
  end
endmodule

// File: rtl/mdu_seq.sv
// Step counter: busy from accepted start until the last step is written.
module mdu_seq #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST_CNT) busy <= 1'b0;
    end
  end

  assign last = busy && (cnt == LAST_CNT);

  assert_count_starts_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cnt == '0));
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] cmd_a,
  input  logic [W-1:0] cmd_b,
  output logic         cmd_ready,
  output logic         busy,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  import mdu_pkg::*;

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] neg_w(input logic [W-1:0] v);
    return (~v) + ONE;
  endfunction

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic sgn);
    return (sgn && v[W-1]) ? neg_w(v) : v;
  endfunction

  function automatic logic [2*W-1:0] fix_product(input logic [2*W-1:0] p, input logic neg);
    return neg ? ((~p) + {{(2*W-1){1'b0}}, 1'b1}) : p;
  endfunction

  mdu_op_e op;
  logic    accept, is_arith, sgn, last, done;

  logic [W:0]   acc_hi, nxt_hi;
  logic [W-1:0] acc_lo, nxt_lo, mag_b;
  logic         is_div, neg_main, neg_rem, div_zero;
  logic [W-1:0] dvd_raw;
  logic [W-1:0] hi_q, lo_q, fin_hi, fin_lo;
  logic [2*W-1:0] prod;

  assign op        = mdu_op_e'(cmd_op);
  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign is_arith  = !cmd_op[2];
  assign sgn       = (op == OP_MULS) || (op == OP_DIVS);
  assign done      = last;

  mdu_seq #(.W(W)) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .start(accept && is_arith),
    .busy (busy),
    .last (last)
  );

  mdu_iter #(.W(W)) u_iter (
    .active(busy),
    .is_div(is_div),
    .acc_hi(acc_hi),
    .acc_lo(acc_lo),
    .mag_b (mag_b),
    .nxt_hi(nxt_hi),
    .nxt_lo(nxt_lo)
  );

  // Sign fix-up and divide-by-zero values applied after the last step.
  always_comb begin
    prod = fix_product({nxt_hi[W-1:0], nxt_lo}, neg_main);
    if (!is_div) begin
      fin_hi = prod[2*W-1:W];
      fin_lo = prod[W-1:0];
    end else if (div_zero) begin
      fin_hi = dvd_raw;
      fin_lo = '1;
    end else begin
      fin_hi = neg_rem  ? neg_w(nxt_hi[W-1:0]) : nxt_hi[W-1:0];
      fin_lo = neg_main ? neg_w(nxt_lo) : nxt_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hi   <= '0;
      acc_lo   <= '0;
      mag_b    <= '0;
      is_div   <= 1'b0;
      neg_main <= 1'b0;
      neg_rem  <= 1'b0;
      div_zero <= 1'b0;
      dvd_raw  <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (accept) begin
        unique case (op)
          OP_MULS, OP_MULU: begin
            acc_hi <= '0;
            acc_lo <= magnitude(cmd_b, sgn);
            mag_b  <= magnitude(cmd_a, sgn);
            is_div <= 1'b0;
          end
          OP_DIVS, OP_DIVU: begin
            acc_hi <= '0;
            acc_lo <= magnitude(cmd_a, sgn);
            mag_b  <= magnitude(cmd_b, sgn);
            is_div <= 1'b1;
          end
          OP_RDHI: begin rd_data <= hi_q; rd_valid <= 1'b1; end
          OP_RDLO: begin rd_data <= lo_q; rd_valid <= 1'b1; end
          OP_WRHI: hi_q <= cmd_a;
          OP_WRLO: lo_q <= cmd_a;
          default: ;
        endcase
        if (is_arith) begin
          neg_main <= sgn && (cmd_a[W-1] ^ cmd_b[W-1]);
          neg_rem  <= sgn && cmd_a[W-1];
          div_zero <= cmd_op[1] && (cmd_b == '0);
          dvd_raw  <= cmd_a;
        end
      end else if (busy) begin
        acc_hi <= nxt_hi;
        acc_lo <= nxt_lo;
        if (done) begin
          hi_q <= fin_hi;
          lo_q <= fin_lo;
        end
      end
    end
  end

  assert_busy_from_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid && !cmd_op[2]));

  assert_hilo_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(hi_q) && $stable(lo_q)));

  assert_read_after_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && cmd_ready && (cmd_op[2:1] == 2'b10)));

  assert_no_read_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !busy);
endmodule

// File: tb/hilo_muldiv_tb.sv
module hilo_muldiv_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [2:0]   cmd_op = '0;
  logic [W-1:0] cmd_a = '0, cmd_b = '0;
  logic         cmd_ready, busy, rd_valid;
  logic [W-1:0] rd_data;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  hilo_muldiv #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_a(cmd_a), .cmd_b(cmd_b), .cmd_ready(cmd_ready), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Present a command; hold it until accepted. Returns cycles spent waiting.
  task automatic issue(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       output int waited);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
    waited = 0;
    while (!cmd_ready) begin
      waited++;
      @(negedge clk);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic read_reg(input logic hi, input string req, input logic [W-1:0] exp);
    int w;
    issue(hi ? 3'd4 : 3'd5, '0, '0, w);
    check({req, " rd_valid"}, 64'(rd_valid), 64'd1);
    check(req, 64'(rd_data), 64'(exp));
  endtask

  // Run an arithmetic command; count busy cycles and watch cmd_ready.
  task automatic run_arith(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                           output int cyc);
    int w;
    int ready_seen;
    ready_seen = 0;
    issue(op, a, b, w);
    cyc = 0;
    while (busy && cyc < 100) begin
      if (cmd_ready) ready_seen++;
      cyc++;
      @(negedge clk);
    end
    check("R8 cmd_ready low while busy", 64'(ready_seen), 64'd0);
  endtask

  function automatic logic [63:0] exp_mul(input logic s, input logic [W-1:0] a, input logic [W-1:0] b);
    longint p;
    if (s) p = longint'($signed(a)) * longint'($signed(b));
    else   p = longint'({32'd0, a}) * longint'({32'd0, b});
    return p;
  endfunction

  function automatic logic [63:0] exp_div(input logic s, input logic [W-1:0] a, input logic [W-1:0] b);
    longint na, nb, q, r;
    if (b == '0) return {a, 32'hFFFF_FFFF};
    na = s ? longint'($signed(a)) : longint'({32'd0, a});
    nb = s ? longint'($signed(b)) : longint'({32'd0, b});
    q = na / nb;
    r = na % nb;
    return {r[31:0], q[31:0]};
  endfunction

  task automatic mul_case(input logic s, input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    int cyc;
    logic [63:0] e;
    e = exp_mul(s, a, b);
    run_arith(s ? 3'd0 : 3'd1, a, b, cyc);
    check("R7 busy cycles (mul)", 64'(cyc), 64'd32);
    read_reg(1'b0, {req, " product low"}, e[31:0]);
    read_reg(1'b1, {req, " product high"}, e[63:32]);
  endtask

  task automatic div_case(input logic s, input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    int cyc;
    logic [63:0] e;
    e = exp_div(s, a, b);
    run_arith(s ? 3'd2 : 3'd3, a, b, cyc);
    check("R7 busy cycles (div)", 64'(cyc), 64'd32);
    read_reg(1'b0, {req, " quotient"}, e[31:0]);
    read_reg(1'b1, {req, " remainder"}, e[63:32]);
  endtask

  task automatic t_reset;
    check("R1 busy after reset", 64'(busy), 64'd0);
    check("R1 rd_valid after reset", 64'(rd_valid), 64'd0);
    check("R1 cmd_ready after reset", 64'(cmd_ready), 64'd1);
    read_reg(1'b1, "R1 high after reset", '0);
    read_reg(1'b0, "R1 low after reset", '0);
  endtask

  task automatic t_mul_unsigned;
    mul_case(1'b0, 32'd7, 32'd6, "R2");
    mul_case(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
    mul_case(1'b0, 32'h1234_5678, 32'h9ABC_DEF0, "R2");
  endtask

  task automatic t_mul_signed;
    mul_case(1'b1, -32'sd3, 32'd5, "R3");
    mul_case(1'b1, -32'sd7, -32'sd9, "R3");
    mul_case(1'b1, 32'h8000_0000, 32'h8000_0000, "R3");
    mul_case(1'b1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R3");
  endtask

  task automatic t_div_unsigned;
    div_case(1'b0, 32'd100, 32'd7, "R4");
    div_case(1'b0, 32'hFFFF_FFFF, 32'd3, "R4");
    div_case(1'b0, 32'd5, 32'd9, "R4");
  endtask

  task automatic t_div_signed;
    div_case(1'b1, -32'sd7, 32'd2, "R5");
    div_case(1'b1, 32'd7, -32'sd2, "R5");
    div_case(1'b1, -32'sd7, -32'sd2, "R5");
    div_case(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, "R5");
  endtask

  task automatic t_div_zero;
    div_case(1'b1, -32'sd5, 32'd0, "R6");
    div_case(1'b0, 32'd123, 32'd0, "R6");
  endtask

  task automatic t_stall;
    int w;
    logic [63:0] e;
    // R8: move-from held during a multiply returns the new low word.
    e = exp_mul(1'b0, 32'h0001_0003, 32'h0002_0005);
    issue(3'd1, 32'h0001_0003, 32'h0002_0005, w);
    issue(3'd5, '0, '0, w);
    check("R8 move-from waited", 64'(w > 0), 64'd1);
    check("R8 held read rd_valid", 64'(rd_valid), 64'd1);
    check("R8 held read returns new low", 64'(rd_data), 64'(e[31:0]));
    // R8: move-to held during a divide replaces the remainder.
    issue(3'd3, 32'd50, 32'd6, w);
    issue(3'd6, 32'hAAAA_5555, '0, w);
    check("R8 move-to waited", 64'(w > 0), 64'd1);
    read_reg(1'b1, "R8 held write wins over remainder", 32'hAAAA_5555);
    read_reg(1'b0, "R8 quotient kept", 32'd8);
  endtask

  task automatic t_moves;
    int w;
    issue(3'd6, 32'hCAFE_0001, '0, w);
    issue(3'd7, 32'h0BAD_F00D, '0, w);
    read_reg(1'b1, "R10 move-to high", 32'hCAFE_0001);
    read_reg(1'b0, "R10 move-to low", 32'h0BAD_F00D);
    issue(3'd7, 32'h1111_2222, '0, w);
    read_reg(1'b1, "R10 high untouched by move-to low", 32'hCAFE_0001);
    // R9: rd_valid is a single-cycle pulse.
    issue(3'd4, '0, '0, w);
    check("R9 rd_valid set", 64'(rd_valid), 64'd1);
    @(negedge clk);
    check("R9 rd_valid drops", 64'(rd_valid), 64'd0);
  endtask

  initial begin
    #2_000_000;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mul_unsigned();
    t_mul_signed();
    t_div_unsigned();
    t_div_signed();
    t_div_zero();
    t_stall();
    t_moves();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule